// File: doc/BRIEF.md
# Rotate and Shift Execution Unit

This block is the shift and rotate datapath of a 32-bit integer execution stage. It is purely combinational: given the first source operand, the second source operand, the 5-bit immediate amount field and the 6-bit extended opcode of an R-type instruction, it returns the 32-bit result and a flag saying whether the opcode belongs to this unit. Register-file reads, forwarding and the other ALU functions are handled elsewhere.

Nine opcodes are decoded. They cover rotate left, rotate right, logical left shift, logical right shift and arithmetic right shift. Each has a register-amount form, which takes the amount from the low five bits of the second operand. Rotate left and the three shifts also have an immediate-amount form, which takes the amount from the instruction's IMM5 field (instruction bits 10:6, already extracted onto `shamt_imm`). There is no immediate right rotate, because a left rotate by 32−n gives the same result. There is no arithmetic left shift.

The unit has no storage and no handshake. Results settle in the same cycle the inputs are presented. The caller qualifies `res_ok` with its own issue valid.

Top module: `rs_shift_unit`

## Requirements
- R1: `funct` = 0x03 rotates `src_a` left by `src_b[4:0]`, and bits leaving bit 31 re-enter at bit 0; `funct` = 0x02 does the same by `shamt_imm`.
- R2: `funct` = 0x0B rotates `src_a` right by `src_b[4:0]`, and bits leaving bit 0 re-enter at bit 31.
- R3: `funct` = 0x13 (amount `src_b[4:0]`) and 0x12 (amount `shamt_imm`) shift `src_a` left and fill vacated low bits with zeros.
- R4: `funct` = 0x1B (amount `src_b[4:0]`) and 0x1A (amount `shamt_imm`) shift `src_a` right and fill vacated high bits with zeros.
- R5: `funct` = 0x3B (amount `src_b[4:0]`) and 0x3A (amount `shamt_imm`) shift `src_a` right and fill vacated high bits with copies of `src_a[31]`.
- R6: For any of the nine listed codes with an effective amount of 0, `result` equals `src_a` and `res_ok` is 1.
- R7: Any `funct` value outside the nine listed codes gives `res_ok` = 0 and `result` = 0. This includes 0x0A, which has no immediate right rotate.
- R8: For any operand and any n in 0..31, the result of 0x0B with amount n equals the result of 0x02 with amount (32−n) mod 32.
- R9: In register forms, `src_b[31:5]` and `shamt_imm` have no effect on `result`. In immediate forms, `src_b` has no effect on `result`.
- R10: Every listed code drives `res_ok` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 32 | Value to be shifted or rotated |
| src_b | input | 32 | Second operand; its bits 4:0 give the amount in register forms |
| shamt_imm | input | 5 | Immediate amount field (instruction bits 10:6) |
| funct | input | 6 | Extended opcode selecting the operation |
| result | output | 32 | Shifted or rotated value, zero when not decoded |
| res_ok | output | 1 | High when `funct` is one of the nine supported codes |

## Verification
The bench builds the unit with its default width of 32, which is the only width the opcode set defines. At that width every one of the 32 amounts can be swept exhaustively for each of the nine opcodes, with several random operands per amount. All 64 opcode values are also applied, so every unlisted code is covered. The same width makes it possible to pair each register right rotate with the immediate left rotate by 32−n, and to toggle the ignored operand bits while the result is held fixed.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam logic [5:0] FN_ROL  = 6'h03;
  localparam logic [5:0] FN_ROLI = 6'h02;
  localparam logic [5:0] FN_ROR  = 6'h0B;
  localparam logic [5:0] FN_SLL  = 6'h13;
  localparam logic [5:0] FN_SLLI = 6'h12;
  localparam logic [5:0] FN_SRL  = 6'h1B;
  localparam logic [5:0] FN_SRLI = 6'h1A;
  localparam logic [5:0] FN_SRA  = 6'h3B;
  localparam logic [5:0] FN_SRAI = 6'h3A;

  typedef enum logic [1:0] {
    K_ROT = 2'd0,
    K_SHL = 2'd1,
    K_SHR = 2'd2
  } rs_kind_e;

  typedef struct packed {
    logic     hit;
    rs_kind_e kind;
    logic     to_right;
    logic     arith;
    logic     from_imm;
  } rs_ctrl_t;
endpackage

// File: rtl/rs_decode.sv
module rs_decode
  import rs_pkg::*;
(
  input  logic [5:0] funct,
  output rs_ctrl_t   ctrl
);
  always_comb begin
    ctrl = '{hit: 1'b0, kind: K_ROT, to_right: 1'b0, arith: 1'b0, from_imm: 1'b0};
    unique case (funct)
      FN_ROL:  ctrl = '{hit: 1'b1, kind: K_ROT, to_right: 1'b0, arith: 1'b0, from_imm: 1'b0};
      FN_ROLI: ctrl = '{hit: 1'b1, kind: K_ROT, to_right: 1'b0, arith: 1'b0, from_imm: 1'b1};
      FN_ROR:  ctrl = '{hit: 1'b1, kind: K_ROT, to_right: 1'b1, arith: 1'b0, from_imm: 1'b0};
      FN_SLL:  ctrl = '{hit: 1'b1, kind: K_SHL, to_right: 1'b0, arith: 1'b0, from_imm: 1'b0};
      FN_SLLI: ctrl = '{hit: 1'b1, kind: K_SHL, to_right: 1'b0, arith: 1'b0, from_imm: 1'b1};
      FN_SRL:  ctrl = '{hit: 1'b1, kind: K_SHR, to_right: 1'b1, arith: 1'b0, from_imm: 1'b0};
      FN_SRLI: ctrl = '{hit: 1'b1, kind: K_SHR, to_right: 1'b1, arith: 1'b0, from_imm: 1'b1};
      FN_SRA:  ctrl = '{hit: 1'b1, kind: K_SHR, to_right: 1'b1, arith: 1'b1, from_imm: 1'b0};
      FN_SRAI: ctrl = '{hit: 1'b1, kind: K_SHR, to_right: 1'b1, arith: 1'b1, from_imm: 1'b1};
      default: ;
    endcase
  end
endmodule

// File: rtl/rs_rotator.sv
module rs_rotator #(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   dout
);
  logic [W-1:0] stage [0:SHW];
  assign stage[0] = din;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int K = 1 << s;
    logic [W-1:0] turned;
    assign turned = {stage[s][W-1-K:0], stage[s][W-1:W-K]};
    assign stage[s+1] = amt[s] ? turned : stage[s];
  end

  assign dout = stage[SHW];
endmodule

// File: rtl/rs_fill_mask.sv
module rs_fill_mask #(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [SHW-1:0] amt,
  input  logic           shifting,
  input  logic           to_right,
  output logic [W-1:0]   keep
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_low;
    logic from_high;
    assign from_low  = int'(amt) <= i;
    assign from_high = int'(amt) <= (W - 1 - i);
    assign keep[i] = !shifting || (to_right ? from_high : from_low);
  end
endmodule

// File: rtl/rs_shift_unit.sv
module rs_shift_unit
  import rs_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   src_a,
  input  logic [W-1:0]   src_b,
  input  logic [SHW-1:0] shamt_imm,
  input  logic [5:0]     funct,
  output logic [W-1:0]   result,
  output logic           res_ok
);
  rs_ctrl_t       ctrl;
  logic [SHW-1:0] amt;
  logic [SHW-1:0] rot_amt;
  logic [W-1:0]   turned;
  logic [W-1:0]   keep;
  logic [W-1:0]   fill;

  rs_decode u_dec (.funct(funct), .ctrl(ctrl));

  assign amt     = ctrl.from_imm ? shamt_imm : src_b[SHW-1:0];
  assign rot_amt = ctrl.to_right ? SHW'(~amt + 1'b1) : amt;

  rs_rotator #(.W(W)) u_rot (.din(src_a), .amt(rot_amt), .dout(turned));

  rs_fill_mask #(.W(W)) u_mask (
    .amt      (amt),
    .shifting (ctrl.kind != K_ROT),
    .to_right (ctrl.to_right),
    .keep     (keep)
  );

  assign fill   = ctrl.arith ? {W{src_a[W-1]}} : '0;
  assign res_ok = ctrl.hit;
  assign result = ctrl.hit ? ((turned & keep) | (fill & ~keep)) : '0;

  always_comb begin
    if (!res_ok)
      p_idle_zero_r7: assert (result == '0);
    if (res_ok && amt == '0)
      p_zero_amt_passthru_r6: assert (result == src_a);
    if (res_ok && ctrl.kind == K_ROT)
      p_rotate_keeps_ones_r1: assert ($countones(result) == $countones(src_a));
    if (res_ok && ctrl.arith)
      p_sign_kept_r5: assert (result[W-1] == src_a[W-1]);
    if (res_ok && ctrl.kind == K_SHR && !ctrl.arith && amt != '0)
      p_msb_cleared_r4: assert (result[W-1] == 1'b0);
    if (res_ok && ctrl.kind == K_SHL && amt != '0)
      p_lsb_cleared_r3: assert (result[0] == 1'b0);
  end
endmodule

// File: tb/test_rs_shift_unit.sv
module test_rs_shift_unit;
  logic        clk = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [4:0]  shamt_imm = '0;
  logic [5:0]  funct = '0;
  logic [31:0] result;
  logic        res_ok;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rs_shift_unit i_rs_shift_unit (
    .src_a(src_a), .src_b(src_b), .shamt_imm(shamt_imm),
    .funct(funct), .result(result), .res_ok(res_ok)
  );

  localparam logic [5:0] CODES [0:8] = '{6'h03, 6'h02, 6'h0B, 6'h13, 6'h12,
                                         6'h1B, 6'h1A, 6'h3B, 6'h3A};

  function automatic string req_of(input logic [5:0] f);
    case (f)
      6'h03, 6'h02: return "R1";
      6'h0B:        return "R2";
      6'h13, 6'h12: return "R3";
      6'h1B, 6'h1A: return "R4";
      6'h3B, 6'h3A: return "R5";
      default:      return "R7";
    endcase
  endfunction

  task automatic model(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] im, output logic [31:0] r, output logic ok);
    int n;
    ok = 1'b1;
    r = '0;
    n = (f == 6'h02 || f == 6'h12 || f == 6'h1A || f == 6'h3A) ? int'(im) : int'(b[4:0]);
    case (f)
      6'h03, 6'h02: for (int i = 0; i < 32; i++) r[(i + n) % 32] = a[i];
      6'h0B:        for (int i = 0; i < 32; i++) r[i] = a[(i + n) % 32];
      6'h13, 6'h12: for (int i = 0; i < 32; i++) r[i] = (i >= n) ? a[i - n] : 1'b0;
      6'h1B, 6'h1A: for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? a[i + n] : 1'b0;
      6'h3B, 6'h3A: for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? a[i + n] : a[31];
      default:      ok = 1'b0;
    endcase
  endtask

  task automatic apply(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] im);
    @(posedge clk);
    #1;
    funct = f; src_a = a; src_b = b; shamt_imm = im;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] exp_r, input logic exp_ok);
    n_vec++;
    if (result !== exp_r || res_ok !== exp_ok) begin
      n_bad++;
      $display("FAIL %s funct=%h a=%h b=%h imm=%0d: got result=%h ok=%b, expected result=%h ok=%b",
               req, funct, src_a, src_b, shamt_imm, result, res_ok, exp_r, exp_ok);
    end
  endtask

  task automatic run_one(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] im, input string req);
    logic [31:0] er;
    logic eo;
    model(f, a, b, im, er, eo);
    apply(f, a, b, im);
    check(req, er, eo);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        n_bad++;
        $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] a, b, r1, r2;
    logic [4:0]  m;
    // Idle state: code 0 is not decoded (R7)
    @(negedge clk);
    check("R7 idle", 32'h0, 1'b0);

    // Sweep every listed code over all amounts with random operands (R1-R5 each tagged)
    for (int c = 0; c < 9; c++) begin
      for (int n = 0; n < 32; n++) begin
        for (int k = 0; k < 3; k++) begin
          a = $urandom();
          b = {$urandom()} & 32'hFFFF_FFE0 | 32'(n);
          m = 5'(n);
          run_one(CODES[c], a, b, m, req_of(CODES[c]));
        end
      end
    end

    // Fixed patterns: sign fill vs zero fill on a negative value (R5, R4)
    run_one(6'h3B, 32'h8000_0000, 32'd31, 5'd0, "R5");
    check("R5 full sign fill", 32'hFFFF_FFFF, 1'b1);
    run_one(6'h1B, 32'h8000_0000, 32'd31, 5'd0, "R4");
    check("R4 single bit", 32'h0000_0001, 1'b1);
    run_one(6'h03, 32'h8000_0001, 32'd1, 5'd0, "R1");
    check("R1 wrap", 32'h0000_0003, 1'b1);
    run_one(6'h0B, 32'h8000_0001, 32'd1, 5'd0, "R2");
    check("R2 wrap", 32'hC000_0000, 1'b1);

    // Zero amount passes operand through (R6)
    for (int c = 0; c < 9; c++) begin
      a = $urandom();
      apply(CODES[c], a, 32'hFFFF_FFE0, 5'd0);
      check("R6", a, 1'b1);
    end

    // All 64 codes: listed ones valid (R10), others zero (R7)
    for (int f = 0; f < 64; f++) begin
      a = $urandom();
      run_one(6'(f), a, 32'd7, 5'd9, (req_of(6'(f)) == "R7") ? "R7" : "R10");
    end

    // Right rotate equals immediate left rotate by 32-n (R8)
    for (int n = 0; n < 32; n++) begin
      a = $urandom();
      apply(6'h0B, a, 32'(n), 5'd0);
      r1 = result;
      apply(6'h02, a, 32'h0, 5'((32 - n) % 32));
      r2 = result;
      n_vec++;
      if (r1 !== r2) begin
        n_bad++;
        $display("FAIL R8 n=%0d: got %h, expected %h", n, r2, r1);
      end
    end

    // Ignored fields (R9)
    for (int c = 0; c < 9; c++) begin
      a = $urandom();
      b = $urandom();
      m = 5'($urandom());
      apply(CODES[c], a, b, m);
      r1 = result;
      if (CODES[c][0]) apply(CODES[c], a, {~b[31:5], b[4:0]}, ~m);
      else             apply(CODES[c], a, ~b, m);
      n_vec++;
      if (result !== r1) begin
        n_bad++;
        $display("FAIL R9 funct=%h: got %h, expected %h", CODES[c], result, r1);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule